// File: doc/BRIEF.md
# Byte-stream to Wishbone bridge

This block is a bus master that is driven by a plain byte stream, for example the receive side of a serial port. Each frame on the stream starts with a command byte, then a burst length byte, then a four-byte word address, all taken from a valid/ready byte sink. A write command then takes one 32-bit data word per burst entry from the same stream and issues one Wishbone classic write for each word. A read command issues one Wishbone classic read for each burst entry. Each returned word is sent back as four bytes on a valid/ready byte source.

Four command codes select the direction and the address mode. In incrementing mode the word address steps by one after every word. In fixed mode every word of the burst uses the same address. While a bus cycle or a read response is in progress, the sink is stalled. After the last word of a burst, the bridge waits for the next command byte.

Top module: `strm_wb_bridge`

## Requirements
- R1: A frame is a command byte, a length byte, four word-address bytes with the most significant byte first, then for writes four bytes per data word with the most significant byte first. The bus address is the word address shifted left by two, so wb_adr_o[1:0] is always 0.
- R2: The command codes are 0x01 for an incrementing write, 0x02 for an incrementing read, 0x03 for a fixed write and 0x04 for a fixed read.
- R3: Any other command byte is consumed and dropped, and the next byte is again taken as a command byte.
- R4: In an incrementing burst, word k of the burst goes to word address A+k.
- R5: In a fixed burst, every word of the burst goes to word address A.
- R6: For a write, wb_cyc_o, wb_stb_o and wb_we_o are high and wb_sel_o is 4'hF. These signals and the address stay unchanged until wb_ack_i is seen.
- R7: For a read, wb_we_o is low. The word latched on wb_ack_i is sent on the source as four bytes, most significant byte first. A byte is held stable while src_ready_i is low. The next read starts only after the fourth byte has been accepted.
- R8: A length byte of 0 ends the frame after the address bytes, with no bus cycle.
- R9: sink_ready_o is low while wb_cyc_o is high or while a read response is being sent.
- R10: After reset, wb_cyc_o, wb_stb_o and src_valid_o are low and sink_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sink_data_i | input | 8 | Incoming stream byte |
| sink_valid_i | input | 1 | Incoming byte valid |
| sink_ready_o | output | 1 | Bridge accepts the incoming byte |
| src_data_o | output | 8 | Outgoing read-response byte |
| src_valid_o | output | 1 | Outgoing byte valid |
| src_ready_i | input | 1 | Downstream accepts the outgoing byte |
| wb_adr_o | output | 32 | Wishbone byte address |
| wb_dat_o | output | 32 | Wishbone write data |
| wb_dat_i | input | 32 | Wishbone read data |
| wb_sel_o | output | 4 | Wishbone byte selects |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_ack_i | input | 1 | Wishbone acknowledge |

## Verification
Two events can coincide in one cycle: the acknowledge that ends the last bus cycle of a burst, and the first byte of the next frame waiting on the sink. The bench provokes this by sending frames back to back, so the next command byte is already valid while the slave, which can add wait states, holds its acknowledge. A monitor counts every sink handshake that happens while the bus cycle is open or a response byte is pending, and that count must stay zero. The memory contents after the second frame show whether the waiting byte was taken as a command and not as data.

// File: rtl/strm_wb_pkg.sv
package strm_wb_pkg;
  typedef enum logic [7:0] {
    CMD_WR_INC = 8'h01,
    CMD_RD_INC = 8'h02,
    CMD_WR_FIX = 8'h03,
    CMD_RD_FIX = 8'h04
  } cmd_e;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_LEN,
    ST_ADR,
    ST_WDAT,
    ST_WBUS,
    ST_RBUS,
    ST_RSEND
  } state_e;
endpackage

// File: rtl/strm_wb_gather.sv
module strm_wb_gather #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [7:0]        byte_i,
  output logic              last_o,
  output logic [WORD_W-1:0] word_o,
  output logic [WORD_W-1:0] word_next_o
);
  localparam int unsigned NBYTES = WORD_W / 8;
  localparam int unsigned CNT_W  = $clog2(NBYTES);

  // counter is exactly wide enough to wrap to zero after the last byte
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shift_q;

  assign last_o      = (cnt_q == CNT_W'(NBYTES - 1));
  assign word_next_o = {shift_q[WORD_W-9:0], byte_i};
  assign word_o      = shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (push_i) begin
      cnt_q   <= cnt_q + 1'b1;
      shift_q <= word_next_o;
    end
  end

  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && last_o) |=> (cnt_q == '0));
endmodule

// File: rtl/strm_wb_emit.sv
module strm_wb_emit #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [7:0]        data_o,
  output logic              done_o
);
  localparam int unsigned NBYTES = WORD_W / 8;
  localparam int unsigned CNT_W  = $clog2(NBYTES);

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shift_q;
  logic              fire;

  assign valid_o = busy_q;
  assign data_o  = shift_q[WORD_W-1 -: 8];
  assign fire    = busy_q && ready_i;
  assign done_o  = fire && (cnt_q == CNT_W'(NBYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (load_i) begin
      busy_q  <= 1'b1;
      shift_q <= word_i;
    end else if (fire) begin
      cnt_q   <= cnt_q + 1'b1;
      shift_q <= shift_q << 8;
      if (done_o) busy_q <= 1'b0;
    end
  end

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
  p_load_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_q);
endmodule

// File: rtl/strm_wb_bridge.sv
module strm_wb_bridge
  import strm_wb_pkg::*;
#(
  parameter int unsigned ADR_W = 32,
  parameter int unsigned DAT_W = 32,
  parameter int unsigned LEN_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [7:0]         sink_data_i,
  input  logic               sink_valid_i,
  output logic               sink_ready_o,
  output logic [7:0]         src_data_o,
  output logic               src_valid_o,
  input  logic               src_ready_i,
  output logic [ADR_W-1:0]   wb_adr_o,
  output logic [DAT_W-1:0]   wb_dat_o,
  input  logic [DAT_W-1:0]   wb_dat_i,
  output logic [DAT_W/8-1:0] wb_sel_o,
  output logic               wb_we_o,
  output logic               wb_cyc_o,
  output logic               wb_stb_o,
  input  logic               wb_ack_i
);
  localparam int unsigned SEL_W = DAT_W / 8;
  localparam int unsigned OFS_W = $clog2(SEL_W);

  state_e            st_q, st_d;
  logic [7:0]        cmd_q;
  logic [LEN_W-1:0]  rem_q;
  logic [ADR_W-1:0]  addr_q;
  logic              push, g_last, e_done, e_load;
  logic [DAT_W-1:0]  g_word, g_next;
  logic              cmd_ok, is_wr, is_inc, word_end, bus_on;

  // whole-byte compares, no bit-field decode
  assign cmd_ok = (sink_data_i == CMD_WR_INC) || (sink_data_i == CMD_RD_INC) ||
                  (sink_data_i == CMD_WR_FIX) || (sink_data_i == CMD_RD_FIX);
  assign is_wr  = (cmd_q == CMD_WR_INC) || (cmd_q == CMD_WR_FIX);
  assign is_inc = (cmd_q == CMD_WR_INC) || (cmd_q == CMD_RD_INC);

  assign sink_ready_o = (st_q == ST_CMD) || (st_q == ST_LEN) ||
                        (st_q == ST_ADR) || (st_q == ST_WDAT);
  assign push   = sink_valid_i && sink_ready_o &&
                  ((st_q == ST_ADR) || (st_q == ST_WDAT));
  assign bus_on = (st_q == ST_WBUS) || (st_q == ST_RBUS);
  assign e_load = (st_q == ST_RBUS) && wb_ack_i;

  assign word_end = ((st_q == ST_WBUS) && wb_ack_i) || ((st_q == ST_RSEND) && e_done);

  assign wb_cyc_o = bus_on;
  assign wb_stb_o = bus_on;
  assign wb_we_o  = (st_q == ST_WBUS);
  assign wb_sel_o = '1;
  assign wb_adr_o = {addr_q[ADR_W-OFS_W-1:0], {OFS_W{1'b0}}};
  assign wb_dat_o = g_word;

  strm_wb_gather #(.WORD_W(DAT_W)) u_gather (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .byte_i      (sink_data_i),
    .last_o      (g_last),
    .word_o      (g_word),
    .word_next_o (g_next)
  );

  strm_wb_emit #(.WORD_W(DAT_W)) u_emit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (e_load),
    .word_i  (wb_dat_i),
    .ready_i (src_ready_i),
    .valid_o (src_valid_o),
    .data_o  (src_data_o),
    .done_o  (e_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_CMD:  if (sink_valid_i && cmd_ok) st_d = ST_LEN;
      ST_LEN:  if (sink_valid_i) st_d = ST_ADR;
      ST_ADR:  if (sink_valid_i && g_last) begin
                 if (rem_q == '0) st_d = ST_CMD;
                 else st_d = is_wr ? ST_WDAT : ST_RBUS;
               end
      ST_WDAT: if (sink_valid_i && g_last) st_d = ST_WBUS;
      ST_WBUS: if (wb_ack_i) st_d = (rem_q == LEN_W'(1)) ? ST_CMD : ST_WDAT;
      ST_RBUS: if (wb_ack_i) st_d = ST_RSEND;
      ST_RSEND: if (e_done) st_d = (rem_q == LEN_W'(1)) ? ST_CMD : ST_RBUS;
      default: st_d = ST_CMD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_CMD;
      cmd_q  <= '0;
      rem_q  <= '0;
      addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_CMD && sink_valid_i && cmd_ok) cmd_q <= sink_data_i;
      if (st_q == ST_LEN && sink_valid_i) rem_q <= LEN_W'(sink_data_i);
      if (st_q == ST_ADR && push && g_last) addr_q <= ADR_W'(g_next);
      if (word_end) begin
        rem_q <= rem_q - 1'b1;
        if (is_inc) addr_q <= addr_q + 1'b1;
      end
    end
  end

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cyc_o && wb_stb_o && !wb_ack_i) |=>
      (wb_cyc_o && wb_stb_o && $stable(wb_adr_o) && $stable(wb_we_o) && $stable(wb_dat_o)));
  p_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cyc_o || src_valid_o) |-> !sink_ready_o);
  p_no_overlap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_valid_o |-> !wb_cyc_o);
  p_fixed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cyc_o && wb_ack_i && !is_inc) |=> $stable(wb_adr_o));
  p_aligned_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o |-> (wb_adr_o[OFS_W-1:0] == '0));
endmodule

// File: tb/tb_strm_wb_bridge.sv
`timescale 1ns/1ps
module tb_strm_wb_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sink_data_i = '0;
  logic        sink_valid_i = 1'b0;
  logic        sink_ready_o;
  logic [7:0]  src_data_o;
  logic        src_valid_o;
  logic        src_ready_i = 1'b1;
  logic [31:0] wb_adr_o, wb_dat_o, wb_dat_i;
  logic [3:0]  wb_sel_o;
  logic        wb_we_o, wb_cyc_o, wb_stb_o;
  logic        wb_ack_i;

  int n_chk = 0, n_err = 0;
  int acks = 0, stall_err = 0, hold_err = 0, sel_err = 0;
  int ack_delay = 0, bp_mode = 0, cyc_n = 0;
  logic [31:0] mem [16];
  logic [7:0]  rxq [$];
  logic        pend_q = 1'b0;

  always #2 clk = ~clk;

  strm_wb_bridge dut (
    .clk_i(clk), .rst_ni(rst_n),
    .sink_data_i(sink_data_i), .sink_valid_i(sink_valid_i), .sink_ready_o(sink_ready_o),
    .src_data_o(src_data_o), .src_valid_o(src_valid_o), .src_ready_i(src_ready_i),
    .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_sel_o(wb_sel_o),
    .wb_we_o(wb_we_o), .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_ack_i(wb_ack_i)
  );

  // slave with programmable wait states
  logic        ack_q = 1'b0;
  logic [31:0] rdat_q = '0;
  int          wcnt = 0;
  assign wb_ack_i = ack_q;
  assign wb_dat_i = rdat_q;
  always @(posedge clk) begin
    ack_q <= 1'b0;
    if (wb_cyc_o && wb_stb_o && !ack_q) begin
      if (wcnt < ack_delay) wcnt <= wcnt + 1;
      else begin
        wcnt  <= 0;
        ack_q <= 1'b1;
        if (wb_we_o) mem[wb_adr_o[5:2]] <= wb_dat_o;
        else rdat_q <= mem[wb_adr_o[5:2]];
      end
    end
  end

  // monitor and response collector, away from the active edge
  always @(negedge clk) begin
    cyc_n <= cyc_n + 1;
    if (rst_n) begin
      if (wb_cyc_o && wb_stb_o && wb_ack_i) acks <= acks + 1;
      if (wb_stb_o && (wb_sel_o != 4'hF || wb_adr_o[1:0] != 2'b00)) sel_err <= sel_err + 1;
      if (pend_q && !(wb_cyc_o && wb_stb_o)) hold_err <= hold_err + 1;
      pend_q <= wb_cyc_o && wb_stb_o && !wb_ack_i;
      if (sink_valid_i && sink_ready_o && (wb_cyc_o || src_valid_o)) stall_err <= stall_err + 1;
    end
    src_ready_i = (bp_mode != 0) ? ((cyc_n % 3) != 0) : 1'b1;
    if (rst_n && src_valid_o && src_ready_i) rxq.push_back(src_data_o);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    sink_data_i  = b;
    sink_valid_i = 1'b1;
    while (!sink_ready_o) @(negedge clk);
    @(negedge clk);
    sink_valid_i = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 3; i >= 0; i--) send_byte(w[i*8 +: 8]);
  endtask

  task automatic send_hdr(input logic [7:0] cmd, input logic [7:0] len, input logic [31:0] a);
    send_byte(cmd);
    send_byte(len);
    send_word(a);
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 16; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!wb_cyc_o && !wb_stb_o, "R10 bus idle", {30'd0, wb_cyc_o, wb_stb_o}, 0);
    chk(!src_valid_o, "R10 src idle", 32'(src_valid_o), 0);
    chk(sink_ready_o, "R10 sink ready", 32'(sink_ready_o), 1);
  endtask

  task automatic t_write_inc();
    int a0;
    clear_mem();
    ack_delay = 2;
    a0 = acks;
    send_hdr(8'h01, 8'd3, 32'd2);
    send_word(32'h1122_3344);
    send_word(32'hA5A5_0001);
    send_word(32'hCAFE_F00D);
    // back-to-back frame: command byte waits on the final ack
    send_hdr(8'h01, 8'd1, 32'd6);
    send_word(32'h0BAD_BEEF);
    settle();
    chk(mem[2] == 32'h1122_3344, "R1 R2 R4 inc word0", mem[2], 32'h1122_3344);
    chk(mem[3] == 32'hA5A5_0001, "R4 inc word1", mem[3], 32'hA5A5_0001);
    chk(mem[4] == 32'hCAFE_F00D, "R4 inc word2", mem[4], 32'hCAFE_F00D);
    chk(mem[6] == 32'h0BAD_BEEF, "R9 next frame after ack", mem[6], 32'h0BAD_BEEF);
    chk(acks - a0 == 4, "R6 ack count", 32'(acks - a0), 4);
  endtask

  task automatic t_write_fix();
    clear_mem();
    ack_delay = 1;
    send_hdr(8'h03, 8'd3, 32'd8);
    send_word(32'h0000_0001);
    send_word(32'h0000_0002);
    send_word(32'h7777_8888);
    settle();
    chk(mem[8] == 32'h7777_8888, "R5 fixed last wins", mem[8], 32'h7777_8888);
    chk(mem[9] == 32'hDEAD_0009, "R5 fixed neighbour", mem[9], 32'hDEAD_0009);
  endtask

  task automatic wait_rx(input int n);
    while (rxq.size() < n) @(negedge clk);
    settle();
  endtask

  task automatic t_read_inc();
    logic [31:0] got;
    clear_mem();
    mem[2] = 32'h0102_0304;
    mem[3] = 32'hF0E1_D2C3;
    ack_delay = 2;
    bp_mode = 1;
    rxq.delete();
    send_hdr(8'h02, 8'd2, 32'd2);
    wait_rx(8);
    chk(rxq.size() == 8, "R7 byte count", 32'(rxq.size()), 8);
    got = {rxq[0], rxq[1], rxq[2], rxq[3]};
    chk(got == 32'h0102_0304, "R7 R4 read word0 msb first", got, 32'h0102_0304);
    got = {rxq[4], rxq[5], rxq[6], rxq[7]};
    chk(got == 32'hF0E1_D2C3, "R7 R4 read word1", got, 32'hF0E1_D2C3);
    bp_mode = 0;
  endtask

  task automatic t_read_fix();
    logic [31:0] got;
    clear_mem();
    mem[8] = 32'h5566_7788;
    ack_delay = 0;
    rxq.delete();
    send_hdr(8'h04, 8'd2, 32'd8);
    wait_rx(8);
    got = {rxq[4], rxq[5], rxq[6], rxq[7]};
    chk(got == 32'h5566_7788, "R5 read fixed repeat", got, 32'h5566_7788);
    chk(rxq.size() == 8, "R5 read fixed count", 32'(rxq.size()), 8);
  endtask

  task automatic t_bad_cmd();
    int a0;
    clear_mem();
    a0 = acks;
    send_byte(8'h05);
    send_byte(8'h00);
    send_byte(8'hFF);
    settle();
    chk(acks == a0, "R3 no bus cycle on bad cmd", 32'(acks - a0), 0);
    send_hdr(8'h01, 8'd1, 32'd1);
    send_word(32'h1234_5678);
    settle();
    chk(mem[1] == 32'h1234_5678, "R3 parser back at command", mem[1], 32'h1234_5678);
  endtask

  task automatic t_zero_len();
    int a0;
    clear_mem();
    a0 = acks;
    send_hdr(8'h01, 8'd0, 32'd5);
    settle();
    chk(acks == a0, "R8 zero length no bus", 32'(acks - a0), 0);
    chk(sink_ready_o && !wb_cyc_o, "R8 idle after zero length", 32'(sink_ready_o), 1);
    send_hdr(8'h01, 8'd1, 32'd5);
    send_word(32'h9999_AAAA);
    settle();
    chk(mem[5] == 32'h9999_AAAA, "R8 next frame", mem[5], 32'h9999_AAAA);
  endtask

  initial begin
    fork
      begin
        clear_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_inc();
        t_write_fix();
        t_read_inc();
        t_read_fix();
        t_bad_cmd();
        t_zero_len();
        chk(stall_err == 0, "R9 sink stalled while busy", 32'(stall_err), 0);
        chk(hold_err == 0, "R6 request held until ack", 32'(hold_err), 0);
        chk(sel_err == 0, "R6 R1 sel and alignment", 32'(sel_err), 0);
      end
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule